// File: doc/BRIEF.md
# Target-Aware Round-Robin Request Arbiter

This block collects allocation requests from several clients in front of a mesh-router tile and forwards one of them per cycle to the next tile. Each client owns a private FIFO. A client holds a valid/ready handshake with its FIFO, and a request is taken only in a cycle where the client offers it and the FIFO reports ready. The FIFO head names one of five downstream targets in its low three bits: north, east, south, west or local. Each target has a ready input.

Each cycle, a client is a candidate only if its FIFO is non-empty and the target named by its head request is ready. The candidates are searched in order, starting at a rotating pointer, and the first one found wins. The winner's head is shown on the output with a valid flag and is popped in the same cycle. The pointer then moves to the position just past the winner. Requests in any one FIFO leave in arrival order. Under back-pressure, requests wait in their FIFOs and none are lost.

Top module: `fifo_arb_rr`

## Requirements
- R1: A synchronous active-high reset empties every FIFO, drives `out_valid` low, raises every `in_ready` bit and sets the search pointer to client 0. As a result, the first grant after reset goes to client 0 whenever client 0 is a candidate.
- R2: `in_ready[i]` is low while FIFO i holds `FIFO_DEPTH` entries and is not popped in that cycle. A request offered while it is low is not stored.
- R3: A full FIFO that is popped in a cycle raises `in_ready[i]` in that same cycle, and a request offered then is stored.
- R4: Requests from one client are forwarded in the order in which they were accepted.
- R5: A client whose FIFO is empty is never granted.
- R6: The destination code is held in bits [2:0] of the payload: 0 selects `tgt_rdy_north`, 1 selects `tgt_rdy_east`, 2 selects `tgt_rdy_south`, 3 selects `tgt_rdy_west` and 4 selects `tgt_rdy_local`. Codes 5 to 7 never count as ready. A client is a candidate only if the target named by its head is ready.
- R7: `out_valid` is high exactly in the cycles where at least one candidate exists. In such a cycle, `out_data` equals the winner's head payload and that entry is removed.
- R8: The winner is the first candidate found by searching from the pointer position upward, with wrap-around. After a grant the pointer moves to the winner's index plus one, modulo `N_CLIENTS`. Without a grant the pointer keeps its value.
- R9: With all targets not ready and all FIFOs full, no accepted request is lost or altered. Once the targets become ready, every held request is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_CLIENTS | Per-client request offer |
| in_data | input | N_CLIENTS*REQ_W | Per-client payloads; client i is in slice [i*REQ_W +: REQ_W] |
| in_ready | output | N_CLIENTS | Per-client FIFO ready |
| tgt_rdy_north | input | 1 | North target can accept |
| tgt_rdy_east | input | 1 | East target can accept |
| tgt_rdy_south | input | 1 | South target can accept |
| tgt_rdy_west | input | 1 | West target can accept |
| tgt_rdy_local | input | 1 | Local target can accept |
| out_valid | output | 1 | A winning request is presented |
| out_data | output | REQ_W | Payload of the winning request |

## Verification
The assertions check, on every cycle, the invariants of each grant:
- at most one grant is issued, and only to a candidate;
- a forwarded request always names a target that is ready;
- an empty FIFO is never popped, and a FIFO never overflows;
- a full FIFO with no pop keeps its level;
- the pointer stays put when there is no grant, and a candidate at the pointer wins.

Other properties depend on history and only the bench scenarios can show them: the ordering of requests within each client, the exact rotation sequence, the same-cycle refill of a full FIFO, and complete draining after a back-pressure blockage. The bench checks these against a queue model, using sweeps over every pattern of the five target-ready inputs.

// File: rtl/fifo_arb_pkg.sv
package fifo_arb_pkg;

    localparam int DEST_W  = 3;
    localparam int NUM_TGT = 5;

    typedef enum logic [DEST_W-1:0] {
        DST_NORTH = 3'd0,
        DST_EAST  = 3'd1,
        DST_SOUTH = 3'd2,
        DST_WEST  = 3'd3,
        DST_LOCAL = 3'd4
    } dest_e;

    // rdy bit order: [0]=north [1]=east [2]=south [3]=west [4]=local
    function automatic logic dest_ready(input logic [DEST_W-1:0] code,
                                        input logic [NUM_TGT-1:0] rdy);
        logic r;
        case (code)
            DST_NORTH: r = rdy[0];
            DST_EAST:  r = rdy[1];
            DST_SOUTH: r = rdy[2];
            DST_WEST:  r = rdy[3];
            DST_LOCAL: r = rdy[4];
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/client_fifo.sv
module client_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_vld,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         in_ready,
    output logic         head_vld,
    output logic [W-1:0] head_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full, push;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    assign full      = (st_q.cnt == FULL);
    assign in_ready  = !full || pop;
    assign push      = push_vld && in_ready;
    assign head_vld  = (st_q.cnt != '0);
    assign head_data = st_q.mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.rd  <= '0;
            st_q.wr  <= '0;
            st_q.cnt <= '0;
            st_q.mem <= st_d.mem;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL);                                            // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_vld);                                            // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> (st_q.cnt == $past(st_q.cnt)));            // R2

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cand,
    output logic [N-1:0] gnt,
    output logic         any
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } rr_st_t;

    rr_st_t        st_d, st_q;
    logic [PW-1:0] win;

    always_comb begin
        gnt = '0;
        any = 1'b0;
        win = '0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(st_q.ptr) + i;
            if (idx >= N) idx = idx - N;
            if (!any && cand[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                win      = PW'(idx);
            end
        end
        st_d = st_q;
        if (any) begin
            st_d.ptr = (win == LAST) ? '0 : win + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.ptr <= '0;
        else     st_q     <= st_d;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));                                               // R8
    AST_GNT_IS_CAND: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~cand) == '0);                                         // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cand == '0) |=> $stable(st_q.ptr));                          // R8
    AST_PTR_FIRST: assert property (@(posedge clk) disable iff (rst)
        cand[st_q.ptr] |-> gnt[st_q.ptr]);                            // R8

endmodule

// File: rtl/fifo_arb_rr.sv
module fifo_arb_rr
    import fifo_arb_pkg::*;
#(
    parameter int N_CLIENTS  = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int REQ_W      = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_CLIENTS-1:0]       in_valid,
    input  logic [N_CLIENTS*REQ_W-1:0] in_data,
    output logic [N_CLIENTS-1:0]       in_ready,
    input  logic                       tgt_rdy_north,
    input  logic                       tgt_rdy_east,
    input  logic                       tgt_rdy_south,
    input  logic                       tgt_rdy_west,
    input  logic                       tgt_rdy_local,
    output logic                       out_valid,
    output logic [REQ_W-1:0]           out_data
);

    logic [NUM_TGT-1:0]              tgt_rdy;
    logic [N_CLIENTS-1:0]            head_vld;
    logic [N_CLIENTS-1:0][REQ_W-1:0] head_data;
    logic [N_CLIENTS-1:0]            cand;
    logic [N_CLIENTS-1:0]            gnt;
    logic                            any;

    assign tgt_rdy = {tgt_rdy_local, tgt_rdy_west, tgt_rdy_south,
                      tgt_rdy_east, tgt_rdy_north};

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_client
        client_fifo #(
            .DEPTH (FIFO_DEPTH),
            .W     (REQ_W)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push_vld  (in_valid[g]),
            .push_data (in_data[g*REQ_W +: REQ_W]),
            .pop       (gnt[g]),
            .in_ready  (in_ready[g]),
            .head_vld  (head_vld[g]),
            .head_data (head_data[g])
        );
        assign cand[g] = head_vld[g] &&
                         dest_ready(head_data[g][DEST_W-1:0], tgt_rdy);
    end

    rr_picker #(
        .N (N_CLIENTS)
    ) u_pick (
        .clk  (clk),
        .rst  (rst),
        .cand (cand),
        .gnt  (gnt),
        .any  (any)
    );

    always_comb begin
        out_data = '0;
        for (int i = 0; i < N_CLIENTS; i++) begin
            if (gnt[i]) out_data = head_data[i];
        end
    end
    assign out_valid = any;

    AST_WIN_TGT_READY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> dest_ready(out_data[DEST_W-1:0], tgt_rdy));     // R6
    AST_WIN_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[DEST_W-1:0] <= 3'd4));                // R6
    AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && (in_ready == '1)));             // R1

endmodule

// File: tb/sim_fifo_arb_rr.sv
`timescale 1ns/1ps
module sim_fifo_arb_rr;

    localparam int N = 4;
    localparam int D = 4;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   in_valid = '0;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   in_ready;
    logic [4:0]     tr = '0;
    logic           out_valid;
    logic [W-1:0]   out_data;

    always #2.5 clk = ~clk;

    fifo_arb_rr #(.N_CLIENTS(N), .FIFO_DEPTH(D), .REQ_W(W)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tgt_rdy_north(tr[0]), .tgt_rdy_east(tr[1]), .tgt_rdy_south(tr[2]),
        .tgt_rdy_west(tr[3]), .tgt_rdy_local(tr[4]),
        .out_valid(out_valid), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] mq [N][$];
    int  mptr = 0;
    int  accepted = 0;
    int  granted  = 0;
    int  last_win = -1;
    logic [10:0] seq = '0;
    logic [N-1:0] last_exp_rdy;

    function automatic logic tok(input logic [2:0] c, input logic [4:0] r);
        return (c < 3'd5) ? r[c] : 1'b0;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) mq[i].delete();
        mptr = 0;
    endtask

    // one cycle: drive, check combinational outputs against model, update model
    task automatic step(input logic [N-1:0] v, input logic [3*N-1:0] dst,
                        input logic [4:0] t);
        int w;
        logic [N-1:0] er;
        @(negedge clk);
        tr = t;
        in_valid = v;
        for (int i = 0; i < N; i++) begin
            in_data[i*W +: W] = {2'(i), seq, dst[3*i +: 3]};
            seq++;
        end
        #1;
        w = -1;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (mptr + k) % N;
            if (w < 0 && mq[idx].size() > 0 && tok(mq[idx][0][2:0], t)) w = idx;
        end
        for (int i = 0; i < N; i++) er[i] = (mq[i].size() < D) || (w == i);
        last_exp_rdy = er;
        // R5 R6 R7: valid exactly when a candidate survives both masks
        chk(out_valid == (w >= 0), "R5 R6 R7 out_valid", W'(out_valid), W'(w >= 0));
        // R4 R8: winner choice and in-order payload
        if (w >= 0)
            chk(out_data == mq[w][0], "R4 R8 out_data", out_data, mq[w][0]);
        // R2 R3: per-FIFO ready
        chk(in_ready == er, "R2 R3 in_ready", W'(in_ready), W'(er));
        last_win = w;
        if (w >= 0) begin
            void'(mq[w].pop_front());
            mptr = (w + 1) % N;
            granted++;
        end
        for (int i = 0; i < N; i++)
            if (v[i] && er[i]) begin
                mq[i].push_back(in_data[i*W +: W]);
                accepted++;
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R1: idle state after reset
        chk(out_valid == 1'b0, "R1 out_valid", W'(out_valid), '0);
        chk(in_ready == '1, "R1 in_ready", W'(in_ready), W'({N{1'b1}}));

        // R1: pointer starts at client 0
        step('1, {3'd3, 3'd2, 3'd1, 3'd0}, 5'h1f);
        step('0, '0, 5'h1f);
        chk(last_win == 0 && out_data[W-1:W-2] == 2'd0, "R1 first grant",
            W'(out_data[W-1:W-2]), '0);
        // R8: rotation continues 1,2,3
        for (int k = 1; k < N; k++) begin
            step('0, '0, 5'h1f);
            chk(last_win == k, "R8 rotation", W'(last_win), W'(k));
        end

        // sweep over every target-ready pattern
        for (int rep = 0; rep < 3; rep++) begin
            for (int t = 0; t < 32; t++) begin
                do_reset();
                for (int c = 0; c < 24; c++) begin
                    logic [3*N-1:0] d;
                    for (int i = 0; i < N; i++) begin
                        int r;
                        r = $urandom % 16;
                        d[3*i +: 3] = (r < 15) ? 3'(r % 5) : 3'(5 + ($urandom % 3));
                    end
                    step(4'($urandom), d, (c % 3 == 2) ? 5'($urandom) : 5'(t));
                end
                for (int c = 0; c < 12; c++) step('0, '0, 5'(t));
            end
        end

        // R9: full blockage then drain
        do_reset();
        accepted = 0;
        granted  = 0;
        for (int c = 0; c < 2 * D; c++) begin
            logic [3*N-1:0] d;
            for (int i = 0; i < N; i++) d[3*i +: 3] = 3'(($urandom % 5));
            step('1, d, 5'h00);
        end
        chk(in_ready == '0, "R2 R9 blocked ready", W'(in_ready), '0);
        chk(accepted == N * D, "R9 fill count", W'(accepted), W'(N * D));
        for (int c = 0; c < N * D + 4; c++) step('0, '0, 5'h1f);
        chk(granted == accepted, "R9 drained count", W'(granted), W'(accepted));
        chk(out_valid == 1'b0, "R9 idle after drain", W'(out_valid), '0);

        // R3: full FIFO popped and refilled in the same cycle
        do_reset();
        for (int c = 0; c < D; c++) step(4'b0001, '0, 5'h00);
        step(4'b0001, '0, 5'h00);
        chk(last_exp_rdy[0] == 1'b0, "R2 full no pop", W'(last_exp_rdy[0]), '0);
        step(4'b0001, '0, 5'h01);
        chk(last_exp_rdy[0] == 1'b1 && last_win == 0, "R3 pop and push",
            W'(in_ready[0]), W'(1));
        chk(mq[0].size() == D, "R3 level kept", W'(mq[0].size()), W'(D));
        for (int c = 0; c < D + 2; c++) step('0, '0, 5'h01);

        // R6: illegal destination codes never drain
        do_reset();
        step(4'b0010, {3'd0, 3'd0, 3'd6, 3'd0}, 5'h1f);
        for (int c = 0; c < 4; c++) step('0, '0, 5'h1f);
        chk(out_valid == 1'b0, "R6 code 6 never ready", W'(out_valid), '0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule